// File: doc/BRIEF.md
# Bridge Configuration Register Bank

This block is a byte-indexed bank of configuration registers for a south-bridge core logic function. A host-side front end presents an 8-bit index, a byte of write data and a write strobe; the bank returns read data for the currently presented index combinationally. The bank holds register-space enables, two I/O base-register enables, a 32-bit top-of-memory limit and a control byte for the interval timer, and it exposes each of these as a live output to the surrounding logic.

Two locations behave unlike plain storage. The boot-status byte reports whether a warm start has been seen since power-up, yet writing a one to the same bit asks the reset controller for a system-wide reset through a one-cycle pulse. The top-of-memory limit keeps its lowest nibble pinned to binary 1100 and is compared continuously against the memory address of an inbound transaction from an external bus master: addresses strictly below the limit raise a forward-upstream indication that steers the cycle towards the host side.

Top module: `bridge_cfg_top`

## Requirements
- R1: After power-on reset, index 46h reads FEh, index 47h reads 00h, index 50h reads 7Bh, and indices 4Ch, 4Dh, 4Eh, 4Fh read FCh, FFh, FFh, FFh; `fn_enable` is 5'h1F, `lpc_bar_en` and `gpio_bar_en` are 0, `tmr_sw_reset` is 0, `tmr_out1_pass` and `tmr_gate1` are 1.
- R2: Bit 0 of index 44h reads 1 until `warm_start_in` is seen high at a clock edge, then reads 0 until the next power-on reset; bits 7:1 of index 44h read 0.
- R3: A write to index 44h with data bit 0 set raises `sys_reset_req` for exactly one cycle, starting at the clock edge that takes the write; a write with bit 0 clear leaves it low.
- R4: Index 46h stores bits 7:1 of written data and bit 0 always reads 0; `fn_enable[4:0]` follows stored bits 5:1 (register spaces 5 down to 1).
- R5: Index 47h keeps only data bit 2 (drives `lpc_bar_en`) and bit 1 (drives `gpio_bar_en`); all other bits read 0.
- R6: Indices 4Ch..4Fh hold the top-of-memory limit least significant byte first; bits 3:0 ignore writes and always read 4'b1100.
- R7: `fwd_upstream` is 1 exactly when `mst_addr` is strictly less than the top-of-memory limit (including its pinned nibble), with no clock delay.
- R8: Index 50h stores the full written byte; `tmr_sw_reset` follows bit 7, `tmr_out1_pass` bit 6 and `tmr_gate1` bit 5.
- R9: Indices 45h and 48h..4Bh read 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| reg_idx | input | 8 | Register index for both read and write |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `reg_idx`, combinational |
| warm_start_in | input | 1 | Warm-start event from the reset controller |
| sys_reset_req | output | 1 | One-cycle system-wide reset request |
| mst_addr | input | 32 | Memory address of an external bus master cycle |
| fwd_upstream | output | 1 | Address is below top-of-memory |
| fn_enable | output | 5 | Register space enables, bit i-1 for space i |
| lpc_bar_en | output | 1 | LPC I/O base register enable |
| gpio_bar_en | output | 1 | GPIO I/O base register enable |
| tmr_sw_reset | output | 1 | Timer software reset |
| tmr_out1_pass | output | 1 | Counter-1 output pass (0 forces it low) |
| tmr_gate1 | output | 1 | Counter-1 gate level |

## Verification
Register writes and the warm-start event land at the clock edge that samples them, so the bench drives at the falling edge and reads the new value one nanosecond after the following rising edge. The reset request is registered: the bench checks it high just after the edge that takes the write and low just after the next edge. Read data and the upstream-forwarding compare are combinational, so those checks sample shortly after the index or address changes with no edge in between.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int IDX_W     = 8;
    localparam int DATA_W    = 8;
    localparam int TOM_W     = 32;
    localparam int TOM_LANES = TOM_W / DATA_W;
    localparam int PIN_W     = 4;
    localparam logic [PIN_W-1:0] PIN_VAL = 4'b1100;

    localparam logic [IDX_W-1:0] IDX_BOOT = 8'h44;
    localparam logic [IDX_W-1:0] IDX_FN   = 8'h46;
    localparam logic [IDX_W-1:0] IDX_MISC = 8'h47;
    localparam logic [IDX_W-1:0] IDX_TOM  = 8'h4C;
    localparam logic [IDX_W-1:0] IDX_TMR  = 8'h50;

    localparam logic [DATA_W-1:0] FN_RST  = 8'hFE;
    localparam logic [DATA_W-1:0] TMR_RST = 8'h7B;

    // bit positions inside the misc byte
    localparam int MISC_GPIO_BIT = 1;
    localparam int MISC_LPC_BIT  = 2;

    typedef struct packed {
        logic                    warm_seen;
        logic                    rst_pulse;
        logic [DATA_W-1:1]       fn_hi;
        logic [1:0]              misc;     // [1]=lpc, [0]=gpio
        logic [TOM_W-1:PIN_W]    tom_hi;
        logic [DATA_W-1:0]       tmr;
    } bcfg_state_t;

    typedef struct packed {
        logic                    boot;
        logic                    fn;
        logic                    misc;
        logic                    tmr;
        logic [TOM_LANES-1:0]    tom;
    } bcfg_wstb_t;

endpackage

// File: rtl/bcfg_wr_decode.sv
module bcfg_wr_decode
    import bcfg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    output bcfg_wstb_t       stb
);
    always_comb begin
        stb.boot = wr_en && (idx == IDX_BOOT);
        stb.fn   = wr_en && (idx == IDX_FN);
        stb.misc = wr_en && (idx == IDX_MISC);
        stb.tmr  = wr_en && (idx == IDX_TMR);
    end

    for (genvar lane = 0; lane < TOM_LANES; lane++) begin : g_tom_lane
        localparam logic [IDX_W-1:0] LANE_IDX = IDX_TOM + IDX_W'(lane);
        assign stb.tom[lane] = wr_en && (idx == LANE_IDX);
    end
endmodule

// File: rtl/bcfg_state.sv
module bcfg_state
    import bcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bcfg_wstb_t        stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              warm_start_in,
    output bcfg_state_t       st_q
);
    bcfg_state_t st_d;
    logic [TOM_W-1:0] tom_full_d;

    always_comb begin
        st_d = st_q;

        // sticky history of warm starts; only the power-on reset clears it
        st_d.warm_seen = st_q.warm_seen | warm_start_in;

        // reset request lives for exactly one cycle
        st_d.rst_pulse = stb.boot && wr_data[0];

        if (stb.fn) begin
            st_d.fn_hi = wr_data[DATA_W-1:1];
        end

        if (stb.misc) begin
            st_d.misc = {wr_data[MISC_LPC_BIT], wr_data[MISC_GPIO_BIT]};
        end

        if (stb.tmr) begin
            st_d.tmr = wr_data;
        end

        // merge byte lanes into the limit; pinned nibble is re-imposed
        tom_full_d = {st_q.tom_hi, PIN_VAL};
        for (int lane = 0; lane < TOM_LANES; lane++) begin
            if (stb.tom[lane]) begin
                tom_full_d[lane*DATA_W +: DATA_W] = wr_data;
            end
        end
        st_d.tom_hi = tom_full_d[TOM_W-1:PIN_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.warm_seen <= 1'b0;
            st_q.rst_pulse <= 1'b0;
            st_q.fn_hi     <= FN_RST[DATA_W-1:1];
            st_q.misc      <= '0;
            st_q.tom_hi    <= '1;
            st_q.tmr       <= TMR_RST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bcfg_rd_mux.sv
module bcfg_rd_mux
    import bcfg_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  bcfg_state_t       st,
    output logic [DATA_W-1:0] rd_data
);
    logic [TOM_W-1:0] tom_full;

    assign tom_full = {st.tom_hi, PIN_VAL};

    always_comb begin
        rd_data = '0;
        unique case (idx)
            IDX_BOOT: rd_data = {{(DATA_W-1){1'b0}}, ~st.warm_seen};
            IDX_FN:   rd_data = {st.fn_hi, 1'b0};
            IDX_MISC: begin
                rd_data[MISC_LPC_BIT]  = st.misc[1];
                rd_data[MISC_GPIO_BIT] = st.misc[0];
            end
            IDX_TMR:  rd_data = st.tmr;
            default: begin
                for (int lane = 0; lane < TOM_LANES; lane++) begin
                    if (idx == IDX_TOM + IDX_W'(lane)) begin
                        rd_data = tom_full[lane*DATA_W +: DATA_W];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/bcfg_limit_cmp.sv
module bcfg_limit_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] limit,
    output logic         below
);
    // strict less-than: an address equal to the limit stays downstream
    assign below = addr < limit;
endmodule

// File: rtl/bridge_cfg_top.sv
module bridge_cfg_top
    import bcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              warm_start_in,
    output logic              sys_reset_req,
    input  logic [TOM_W-1:0]  mst_addr,
    output logic              fwd_upstream,
    output logic [4:0]        fn_enable,
    output logic              lpc_bar_en,
    output logic              gpio_bar_en,
    output logic              tmr_sw_reset,
    output logic              tmr_out1_pass,
    output logic              tmr_gate1
);
    bcfg_wstb_t  stb;
    bcfg_state_t st;

    bcfg_wr_decode u_dec (
        .idx   (reg_idx),
        .wr_en (wr_en),
        .stb   (stb)
    );

    bcfg_state u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .stb           (stb),
        .wr_data       (wr_data),
        .warm_start_in (warm_start_in),
        .st_q          (st)
    );

    bcfg_rd_mux u_rd (
        .idx     (reg_idx),
        .st      (st),
        .rd_data (rd_data)
    );

    bcfg_limit_cmp #(.W(TOM_W)) u_cmp (
        .addr  (mst_addr),
        .limit ({st.tom_hi, PIN_VAL}),
        .below (fwd_upstream)
    );

    assign sys_reset_req = st.rst_pulse;
    assign fn_enable     = st.fn_hi[5:1];
    assign lpc_bar_en    = st.misc[1];
    assign gpio_bar_en   = st.misc[0];
    assign tmr_sw_reset  = st.tmr[7];
    assign tmr_out1_pass = st.tmr[6];
    assign tmr_gate1     = st.tmr[5];
endmodule

// File: rtl/bcfg_checker.sv
module bcfg_checker
    import bcfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  reg_idx,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              warm_start_in,
    input logic              sys_reset_req,
    input logic [TOM_W-1:0]  mst_addr,
    input logic              fwd_upstream
);
    assert_warm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(warm_start_in) && reg_idx == IDX_BOOT) |-> rd_data == 8'h00);

    assert_warm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_idx) == IDX_BOOT && $past(rd_data[0]) == 1'b0
         && reg_idx == IDX_BOOT) |-> rd_data[0] == 1'b0);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sys_reset_req) |->
            ($past(wr_en) && $past(reg_idx) == IDX_BOOT && $past(wr_data[0])));

    assert_fn_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_idx == IDX_FN |-> rd_data[0] == 1'b0);

    assert_tom_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_idx == IDX_TOM |-> rd_data[PIN_W-1:0] == PIN_VAL);

    assert_fwd_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mst_addr == '1 |-> !fwd_upstream);

    assert_fwd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mst_addr == '0 |-> fwd_upstream);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 8'h45 || (reg_idx >= 8'h48 && reg_idx <= 8'h4B)) |-> rd_data == 8'h00);
endmodule

bind bridge_cfg_top bcfg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_idx       (reg_idx),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .warm_start_in (warm_start_in),
    .sys_reset_req (sys_reset_req),
    .mst_addr      (mst_addr),
    .fwd_upstream  (fwd_upstream)
);

// File: tb/bridge_cfg_top_tb_top.sv
`timescale 1ns/1ps
module bridge_cfg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_idx;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic        warm_start_in;
    logic        sys_reset_req;
    logic [31:0] mst_addr;
    logic        fwd_upstream;
    logic [4:0]  fn_enable;
    logic        lpc_bar_en, gpio_bar_en;
    logic        tmr_sw_reset, tmr_out1_pass, tmr_gate1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bridge_cfg_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .warm_start_in(warm_start_in),
        .sys_reset_req(sys_reset_req), .mst_addr(mst_addr),
        .fwd_upstream(fwd_upstream), .fn_enable(fn_enable),
        .lpc_bar_en(lpc_bar_en), .gpio_bar_en(gpio_bar_en),
        .tmr_sw_reset(tmr_sw_reset), .tmr_out1_pass(tmr_out1_pass),
        .tmr_gate1(tmr_gate1)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        reg_idx = idx; wr_data = data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_read(input string req, input logic [7:0] idx, input logic [7:0] exp);
        @(negedge clk);
        reg_idx = idx;
        #1;
        check(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic power_on_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_values();
        expect_read("R1 idx46", 8'h46, 8'hFE);
        expect_read("R1 idx47", 8'h47, 8'h00);
        expect_read("R1 idx50", 8'h50, 8'h7B);
        expect_read("R1 idx4C", 8'h4C, 8'hFC);
        expect_read("R1 idx4D", 8'h4D, 8'hFF);
        expect_read("R1 idx4E", 8'h4E, 8'hFF);
        expect_read("R1 idx4F", 8'h4F, 8'hFF);
        check("R1 fn_enable", {27'h0, fn_enable}, 32'h1F);
        check("R1 bar enables", {30'h0, lpc_bar_en, gpio_bar_en}, 32'h0);
        check("R1 timer outs", {29'h0, tmr_sw_reset, tmr_out1_pass, tmr_gate1}, 32'h3);
        check("R1 sys_reset_req", {31'h0, sys_reset_req}, 32'h0);
    endtask

    task automatic t_warm_status();
        expect_read("R2 no warm yet", 8'h44, 8'h01);
        @(negedge clk); warm_start_in = 1'b1;
        @(negedge clk); warm_start_in = 1'b0;
        expect_read("R2 after warm", 8'h44, 8'h00);
        repeat (3) @(negedge clk);
        expect_read("R2 sticky", 8'h44, 8'h00);
        do_write(8'h44, 8'h00);
        expect_read("R2 write0 keeps", 8'h44, 8'h00);
        power_on_reset();
        expect_read("R2 por clears", 8'h44, 8'h01);
    endtask

    task automatic t_reset_pulse();
        @(negedge clk);
        check("R3 idle low", {31'h0, sys_reset_req}, 32'h0);
        reg_idx = 8'h44; wr_data = 8'h01; wr_en = 1'b1;
        @(posedge clk); #1;
        check("R3 pulse high", {31'h0, sys_reset_req}, 32'h1);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        check("R3 pulse one cycle", {31'h0, sys_reset_req}, 32'h0);
        @(negedge clk);
        reg_idx = 8'h44; wr_data = 8'hFE; wr_en = 1'b1;
        @(posedge clk); #1;
        check("R3 write0 no pulse", {31'h0, sys_reset_req}, 32'h0);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic t_fn_enable();
        do_write(8'h46, 8'h00);
        expect_read("R4 clear", 8'h46, 8'h00);
        check("R4 fn_enable clear", {27'h0, fn_enable}, 32'h00);
        do_write(8'h46, 8'hFF);
        expect_read("R4 bit0 reads 0", 8'h46, 8'hFE);
        do_write(8'h46, 8'h2B);
        expect_read("R4 pattern", 8'h46, 8'h2A);
        check("R4 fn_enable pattern", {27'h0, fn_enable}, 32'h15);
    endtask

    task automatic t_misc_enable();
        do_write(8'h47, 8'hFF);
        expect_read("R5 all ones", 8'h47, 8'h06);
        check("R5 both en", {30'h0, lpc_bar_en, gpio_bar_en}, 32'h3);
        do_write(8'h47, 8'h04);
        check("R5 lpc only", {30'h0, lpc_bar_en, gpio_bar_en}, 32'h2);
        do_write(8'h47, 8'hFA);
        expect_read("R5 gpio only", 8'h47, 8'h02);
        check("R5 gpio out", {30'h0, lpc_bar_en, gpio_bar_en}, 32'h1);
    endtask

    task automatic t_tom_and_fwd();
        @(negedge clk); mst_addr = 32'hFFFF_FFFB; #1;
        check("R7 below reset limit", {31'h0, fwd_upstream}, 32'h1);
        mst_addr = 32'hFFFF_FFFC; #1;
        check("R7 equal reset limit", {31'h0, fwd_upstream}, 32'h0);
        do_write(8'h4C, 8'h35);
        do_write(8'h4D, 8'h12);
        do_write(8'h4E, 8'h00);
        do_write(8'h4F, 8'h00);
        expect_read("R6 low byte pinned", 8'h4C, 8'h3C);
        expect_read("R6 byte1", 8'h4D, 8'h12);
        expect_read("R6 byte3", 8'h4F, 8'h00);
        @(negedge clk); mst_addr = 32'h0000_123B; #1;
        check("R7 just below", {31'h0, fwd_upstream}, 32'h1);
        mst_addr = 32'h0000_123C; #1;
        check("R7 equal", {31'h0, fwd_upstream}, 32'h0);
        mst_addr = 32'h0000_123D; #1;
        check("R7 above", {31'h0, fwd_upstream}, 32'h0);
        mst_addr = 32'h0100_0000; #1;
        check("R7 high byte above", {31'h0, fwd_upstream}, 32'h0);
        do_write(8'h4C, 8'h03);
        expect_read("R6 nibble ignores write", 8'h4C, 8'h0C);
    endtask

    task automatic t_timer();
        do_write(8'h50, 8'hA0);
        expect_read("R8 readback", 8'h50, 8'hA0);
        check("R8 outputs", {29'h0, tmr_sw_reset, tmr_out1_pass, tmr_gate1}, 32'h5);
        do_write(8'h50, 8'h40);
        check("R8 pass only", {29'h0, tmr_sw_reset, tmr_out1_pass, tmr_gate1}, 32'h2);
    endtask

    task automatic t_reserved();
        do_write(8'h45, 8'hFF);
        expect_read("R9 idx45", 8'h45, 8'h00);
        for (int i = 8'h48; i <= 8'h4B; i++) begin
            do_write(8'(i), 8'hFF);
            expect_read("R9 idx48-4B", 8'(i), 8'h00);
        end
        expect_read("R9 fn untouched", 8'h46, 8'h2A);
        expect_read("R9 misc untouched", 8'h47, 8'h02);
        expect_read("R9 tom untouched", 8'h4C, 8'h0C);
        expect_read("R9 timer untouched", 8'h50, 8'h40);
    endtask

    initial begin
        rst_n = 1'b0; reg_idx = 8'h00; wr_en = 1'b0; wr_data = 8'h00;
        warm_start_in = 1'b0; mst_addr = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_warm_status();
        t_reset_pulse();
        t_fn_enable();
        t_misc_enable();
        t_tom_and_fwd();
        t_timer();
        t_reserved();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule